// File: doc/BRIEF.md
# Vertical Scaling Line Sequencer

This block computes the schedule of input lines for a vertical scaler that builds every output line from five input lines. Before a frame, the host presents the input height, the output height, a starting fraction and a line step split into an integer part and a 16-bit fraction. The step is the reciprocal of the scale factor. A one-cycle start pulse captures this configuration. The block then walks a fixed-point position through the input image, one step for each output line.

For each output line the block presents the integer line position (the center), the fraction of the position (the phase that picks filter coefficients) and five input line indices. The indices are adjacent lines around the center in normal mode. In wide mode they are spread apart by the integer step, so that strong down-scaling still covers the whole input span. An index that falls above the first line or below the last line is reflected about that edge and then clamped into the image. Each output line is handed over with a valid/ready handshake. A one-cycle done pulse marks the end of the frame. The filter arithmetic and all memory traffic belong to the blocks around this one.

Top module: `vsl_top`

## Requirements
- R1: After reset, line_valid_o, done_o and busy_o are 0.
- R2: A start pulse while idle captures the configuration. In the next cycle the first line is valid, with center_o = 0 and phase_o = the start fraction.
- R3: Each accepted line (line_valid_o and line_ready_i both high at a clock edge) advances the position by step_int + step_frac/65536. A carry out of the 16-bit phase adds one to center_o.
- R4: With cfg_wide_i = 0, tap k (k = 0..4, element k of tap_idx_o, tap 0 the topmost) is line center + (k - 2) before edge handling.
- R5: With cfg_wide_i = 1, tap k is line center + (k - 2) * S, where S = step_int, or S = 1 when step_int is 0.
- R6: A tap index -j above the image becomes j, clamped to at most H - 1, where H is the input height (H = 0 is treated as 1).
- R7: A tap index H - 1 + j below the image becomes H - 1 - j, clamped to at least 0. No tap index is ever larger than H - 1.
- R8: While line_valid_o is high and line_ready_i is low, center_o, phase_o and tap_idx_o hold their values and line_valid_o stays high.
- R9: Exactly the configured output height of lines is delivered. done_o is high for one cycle, in the cycle after the last line is accepted, with line_valid_o low. With an output height of 0, done_o is high in the cycle after start and no line is delivered.
- R10: A start pulse while busy has no effect on the lines being delivered.
- R11: Configuration inputs that change while busy have no effect until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Captures the configuration and begins a frame when idle |
| cfg_in_height_i | input | 12 | Input image height in lines |
| cfg_out_height_i | input | 12 | Number of output lines to generate |
| cfg_start_frac_i | input | 16 | Initial phase of the position |
| cfg_step_int_i | input | 12 | Integer part of the line step |
| cfg_step_frac_i | input | 16 | Fractional part of the line step (units of 1/65536) |
| cfg_wide_i | input | 1 | 1 selects tap spacing by the integer step |
| busy_o | output | 1 | A frame is in progress |
| line_valid_o | output | 1 | The current line description is valid |
| line_ready_i | input | 1 | The consumer accepts the current line |
| center_o | output | 12 | Integer input line position |
| phase_o | output | 16 | Fractional position, used as the coefficient phase |
| tap_idx_o | output | 5x12 | Edge-corrected input line index for each tap |
| done_o | output | 1 | One-cycle pulse after the last line is accepted |

## Verification
Unit steps in normal mode run each tap index across both image edges, which shows whether reflection and clamping are correct. An integer step of 5 in wide mode reproduces the spread pattern, for example 2, 7, 12, 17, 22 around 12. A wide frame with a zero integer step shows that the spacing falls back to 1. Up-scaling with a fraction-only step checks carry propagation from the phase into the center. Randomly drawn heights, steps, modes and ready patterns check the handshake hold, the line count and the done timing against a bench model. Start pulses and configuration changes in the middle of a frame show that a running frame cannot be disturbed.

// File: rtl/vsl_pkg.sv
package vsl_pkg;
    localparam int LINE_W   = 12;
    localparam int FRAC_W   = 16;
    localparam int NUM_TAPS = 5;
    localparam int MID_TAP  = NUM_TAPS / 2;
    localparam int POS_IW   = LINE_W + 2;
    localparam int SIDX_W   = LINE_W + 4;

    typedef logic [LINE_W-1:0]        line_t;
    typedef logic [FRAC_W-1:0]        frac_t;
    typedef logic [POS_IW-1:0]        ipos_t;
    typedef logic signed [SIDX_W-1:0] sidx_t;

    typedef enum logic {ST_IDLE, ST_EMIT} seq_state_e;

    typedef struct packed {
        line_t in_h;
        line_t out_h;
        frac_t start_frac;
        line_t step_int;
        frac_t step_frac;
        logic  wide;
    } seq_cfg_t;

    typedef struct packed {
        ipos_t ipos;
        frac_t frac;
    } pos_t;

    function automatic line_t last_line(input line_t h);
        return (h == '0) ? '0 : line_t'(h - 1'b1);
    endfunction

    function automatic line_t tap_spacing(input logic wide, input line_t step_int);
        if (!wide)
            return line_t'(1);
        return (step_int == '0) ? line_t'(1) : step_int;
    endfunction

    function automatic sidx_t widen_line(input line_t v);
        return $signed({{(SIDX_W-LINE_W){1'b0}}, v});
    endfunction
endpackage

// File: rtl/vsl_ctrl.sv
module vsl_ctrl
    import vsl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  seq_cfg_t cfg_i,
    input  logic     ready_i,
    output seq_cfg_t cfg_q_o,
    output logic     load_o,
    output logic     adv_o,
    output logic     valid_o,
    output logic     done_o
);
    seq_state_e state_q;
    line_t      count_q;
    seq_cfg_t   cfg_q;
    logic       done_q;
    logic       accept;

    assign accept  = (state_q == ST_EMIT) && ready_i;
    assign load_o  = (state_q == ST_IDLE) && start_i;
    assign adv_o   = accept;
    assign valid_o = (state_q == ST_EMIT);
    assign done_o  = done_q;
    assign cfg_q_o = cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            count_q <= '0;
            cfg_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        cfg_q   <= cfg_i;
                        count_q <= '0;
                        if (cfg_i.out_h == '0)
                            done_q <= 1'b1;
                        else
                            state_q <= ST_EMIT;
                    end
                end
                ST_EMIT: begin
                    if (accept) begin
                        if (count_q == line_t'(cfg_q.out_h - 1'b1)) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            count_q <= count_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vsl_accum.sv
module vsl_accum
    import vsl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_i,
    input  frac_t start_frac_i,
    input  logic  adv_i,
    input  line_t step_int_i,
    input  frac_t step_frac_i,
    output pos_t  pos_o
);
    pos_t              pos_q;
    logic [FRAC_W:0]   frac_sum;
    ipos_t             ipos_next;

    always_comb begin
        frac_sum  = {1'b0, pos_q.frac} + {1'b0, step_frac_i};
        ipos_next = pos_q.ipos + {{(POS_IW-LINE_W){1'b0}}, step_int_i}
                    + {{(POS_IW-1){1'b0}}, frac_sum[FRAC_W]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (load_i) begin
            pos_q.ipos <= '0;
            pos_q.frac <= start_frac_i;
        end else if (adv_i) begin
            pos_q.ipos <= ipos_next;
            pos_q.frac <= frac_sum[FRAC_W-1:0];
        end
    end

    assign pos_o = pos_q;
endmodule

// File: rtl/vsl_mirror.sv
module vsl_mirror
    import vsl_pkg::*;
(
    input  sidx_t idx_i,
    input  line_t hmax_i,
    output line_t line_o
);
    sidx_t h;
    sidx_t refl;

    always_comb begin
        h = widen_line(hmax_i);
        if (idx_i < 0) begin
            refl = -idx_i;
            if (refl > h)
                refl = h;
        end else if (idx_i > h) begin
            refl = (h <<< 1) - idx_i;
            if (refl < 0)
                refl = '0;
        end else begin
            refl = idx_i;
        end
        line_o = refl[LINE_W-1:0];
    end
endmodule

// File: rtl/vsl_tapgen.sv
module vsl_tapgen
    import vsl_pkg::*;
(
    input  ipos_t ipos_i,
    input  line_t in_h_i,
    input  line_t step_int_i,
    input  logic  wide_i,
    output line_t [NUM_TAPS-1:0] taps_o
);
    sidx_t base;
    sidx_t spacing;
    line_t hmax;

    assign base    = $signed({{(SIDX_W-POS_IW){1'b0}}, ipos_i});
    assign spacing = widen_line(tap_spacing(wide_i, step_int_i));
    assign hmax    = last_line(in_h_i);

    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
        localparam int REL = k - MID_TAP;
        sidx_t offset;
        sidx_t raw_idx;

        assign offset  = sidx_t'(REL) * spacing;
        assign raw_idx = base + offset;

        vsl_mirror u_mirror (
            .idx_i  (raw_idx),
            .hmax_i (hmax),
            .line_o (taps_o[k])
        );
    end
endmodule

// File: rtl/vsl_top.sv
module vsl_top
    import vsl_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start_i,
    input  logic [LINE_W-1:0]            cfg_in_height_i,
    input  logic [LINE_W-1:0]            cfg_out_height_i,
    input  logic [FRAC_W-1:0]            cfg_start_frac_i,
    input  logic [LINE_W-1:0]            cfg_step_int_i,
    input  logic [FRAC_W-1:0]            cfg_step_frac_i,
    input  logic                         cfg_wide_i,
    output logic                         busy_o,
    output logic                         line_valid_o,
    input  logic                         line_ready_i,
    output logic [LINE_W-1:0]            center_o,
    output logic [FRAC_W-1:0]            phase_o,
    output logic [NUM_TAPS-1:0][LINE_W-1:0] tap_idx_o,
    output logic                         done_o
);
    seq_cfg_t cfg_in;
    seq_cfg_t cfg_q;
    logic     load;
    logic     adv;
    logic     valid;
    pos_t     pos;
    line_t    act_in_h;
    frac_t    act_step_frac;

    always_comb begin
        cfg_in.in_h       = cfg_in_height_i;
        cfg_in.out_h      = cfg_out_height_i;
        cfg_in.start_frac = cfg_start_frac_i;
        cfg_in.step_int   = cfg_step_int_i;
        cfg_in.step_frac  = cfg_step_frac_i;
        cfg_in.wide       = cfg_wide_i;
    end

    vsl_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .cfg_i   (cfg_in),
        .ready_i (line_ready_i),
        .cfg_q_o (cfg_q),
        .load_o  (load),
        .adv_o   (adv),
        .valid_o (valid),
        .done_o  (done_o)
    );

    vsl_accum u_accum (
        .clk          (clk),
        .rst          (rst),
        .load_i       (load),
        .start_frac_i (cfg_start_frac_i),
        .adv_i        (adv),
        .step_int_i   (cfg_q.step_int),
        .step_frac_i  (cfg_q.step_frac),
        .pos_o        (pos)
    );

    vsl_tapgen u_tapgen (
        .ipos_i     (pos.ipos),
        .in_h_i     (cfg_q.in_h),
        .step_int_i (cfg_q.step_int),
        .wide_i     (cfg_q.wide),
        .taps_o     (tap_idx_o)
    );

    assign act_in_h      = cfg_q.in_h;
    assign act_step_frac = cfg_q.step_frac;
    assign line_valid_o  = valid;
    assign busy_o        = valid;
    assign center_o      = pos.ipos[LINE_W-1:0];
    assign phase_o       = pos.frac;
endmodule

// File: rtl/vsl_checker.sv
module vsl_checker
    import vsl_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  valid,
    input logic                  ready,
    input logic                  done,
    input line_t                 center,
    input frac_t                 phase,
    input line_t [NUM_TAPS-1:0]  taps,
    input line_t                 in_h,
    input frac_t                 step_frac
);
    line_t hmax;
    assign hmax = last_line(in_h);

    // R8: a stalled line keeps its contents
    p_hold_stall_r8: assert property (@(posedge clk) disable iff (rst)
        valid && !ready |=> valid && $stable(center) && $stable(phase) && $stable(taps));

    // R9: done lasts a single cycle
    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: done never overlaps a valid line
    p_done_excl_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !valid);

    // R3: the phase advances by the captured fractional step
    p_phase_step_r3: assert property (@(posedge clk) disable iff (rst)
        valid && ready |=> !valid || (phase == frac_t'($past(phase) + $past(step_frac))));

    // R7: every tap stays inside the image
    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_rng
        p_tap_in_image_r7: assert property (@(posedge clk) disable iff (rst)
            valid |-> taps[k] <= hmax);
    end
endmodule

bind vsl_top vsl_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .valid     (line_valid_o),
    .ready     (line_ready_i),
    .done      (done_o),
    .center    (center_o),
    .phase     (phase_o),
    .taps      (tap_idx_o),
    .in_h      (act_in_h),
    .step_frac (act_step_frac)
);

// File: tb/tb_vsl_top.sv
module tb_vsl_top;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 12;
    localparam int FW = 16;
    localparam int NT = 5;

    logic               clk = 1'b0;
    logic               rst;
    logic               start_i;
    logic [LW-1:0]      cfg_in_height_i;
    logic [LW-1:0]      cfg_out_height_i;
    logic [FW-1:0]      cfg_start_frac_i;
    logic [LW-1:0]      cfg_step_int_i;
    logic [FW-1:0]      cfg_step_frac_i;
    logic               cfg_wide_i;
    logic               busy_o;
    logic               line_valid_o;
    logic               line_ready_i;
    logic [LW-1:0]      center_o;
    logic [FW-1:0]      phase_o;
    logic [NT-1:0][LW-1:0] tap_idx_o;
    logic               done_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vsl_top dut (
        .clk(clk), .rst(rst), .start_i(start_i),
        .cfg_in_height_i(cfg_in_height_i), .cfg_out_height_i(cfg_out_height_i),
        .cfg_start_frac_i(cfg_start_frac_i), .cfg_step_int_i(cfg_step_int_i),
        .cfg_step_frac_i(cfg_step_frac_i), .cfg_wide_i(cfg_wide_i),
        .busy_o(busy_o), .line_valid_o(line_valid_o), .line_ready_i(line_ready_i),
        .center_o(center_o), .phase_o(phase_o), .tap_idx_o(tap_idx_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int ref_reflect(input int idx, input int hmax);
        int r;
        if (idx < 0)          r = (-idx > hmax) ? hmax : -idx;
        else if (idx > hmax)  r = (2*hmax - idx < 0) ? 0 : 2*hmax - idx;
        else                  r = idx;
        return r;
    endfunction

    function automatic longint ref_pos(input int sf, input int si, input int sfr, input int n);
        return longint'(sf) + longint'(n) * ((longint'(si) << 16) + longint'(sfr));
    endfunction

    function automatic int ref_tap(input longint pos, input int k, input int wide,
                                   input int si, input int inh);
        int sp;
        int hmax;
        sp   = (wide != 0 && si != 0) ? si : 1;
        hmax = (inh == 0) ? 0 : inh - 1;
        return ref_reflect(int'(pos >>> 16) + (k - 2) * sp, hmax);
    endfunction

    task automatic run_frame(input int inh, input int outh, input int sf, input int si,
                             input int sfr, input int wide, input int rdy_pct,
                             input bit disturb);
        int  n;
        int  guard;
        bit  rdy;
        bit  have_prev;
        logic [LW-1:0] pc;
        logic [FW-1:0] pp;
        logic [NT-1:0][LW-1:0] pt;
        @(negedge clk);
        cfg_in_height_i  = LW'(inh);
        cfg_out_height_i = LW'(outh);
        cfg_start_frac_i = FW'(sf);
        cfg_step_int_i   = LW'(si);
        cfg_step_frac_i  = FW'(sfr);
        cfg_wide_i       = wide[0];
        start_i          = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 0; guard = 0; have_prev = 0; rdy = 0;
        while (n < outh && guard < 4000) begin
            longint p;
            string tt;
            bit edge_hit;
            guard++;
            p = ref_pos(sf, si, sfr, n);
            if (have_prev && !rdy)
                check(center_o == pc && phase_o == pp && tap_idx_o == pt, "R8",
                      "stalled line changed", longint'(center_o), longint'(pc));
            check(line_valid_o == 1'b1 && done_o == 1'b0, "R9", "valid during frame",
                  longint'(line_valid_o), 1);
            check(center_o == LW'(p >>> 16), (n == 0) ? "R2" : "R3", "center",
                  longint'(center_o), (p >>> 16) & 4095);
            check(phase_o == FW'(p), (n == 0) ? "R2" : "R3", "phase",
                  longint'(phase_o), p & 65535);
            edge_hit = 0;
            for (int k = 0; k < NT; k++) begin
                int raw;
                raw = int'(p >>> 16) + (k - 2) * ((wide != 0 && si != 0) ? si : 1);
                if (raw < 0 || raw > inh - 1) edge_hit = 1;
            end
            tt = (wide != 0) ? "R5" : "R4";
            if (edge_hit) tt = {tt, " R6 R7"};
            for (int k = 0; k < NT; k++)
                check(int'(tap_idx_o[k]) == ref_tap(p, k, wide, si, inh), tt,
                      $sformatf("tap %0d line %0d", k, n), longint'(tap_idx_o[k]),
                      longint'(ref_tap(p, k, wide, si, inh)));
            pc = center_o; pp = phase_o; pt = tap_idx_o; have_prev = 1;
            rdy = (($urandom % 100) < rdy_pct);
            line_ready_i = rdy;
            if (disturb) begin
                // R10 R11: these must not disturb the running frame
                start_i          = $urandom_range(0, 1) == 1;
                cfg_in_height_i  = LW'($urandom);
                cfg_out_height_i = LW'($urandom);
                cfg_start_frac_i = FW'($urandom);
                cfg_step_int_i   = LW'($urandom);
                cfg_step_frac_i  = FW'($urandom);
                cfg_wide_i       = $urandom_range(0, 1) == 1;
            end
            @(negedge clk);
            if (rdy) n++;
        end
        start_i = 1'b0;
        line_ready_i = 1'b0;
        check(n == outh, disturb ? "R10 R11" : "R9", "lines delivered", n, outh);
        check(done_o == 1'b1 && line_valid_o == 1'b0 && busy_o == 1'b0, "R9",
              "done after last line", longint'(done_o), 1);
        @(negedge clk);
        check(done_o == 1'b0 && line_valid_o == 1'b0, "R9", "done single cycle",
              longint'(done_o), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        rst = 1'b1; start_i = 1'b0; line_ready_i = 1'b0;
        cfg_in_height_i = '0; cfg_out_height_i = '0; cfg_start_frac_i = '0;
        cfg_step_int_i = '0; cfg_step_frac_i = '0; cfg_wide_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(line_valid_o == 0 && done_o == 0 && busy_o == 0, "R1", "reset state",
              longint'({line_valid_o, done_o, busy_o}), 0);

        // unit step, normal taps, both edges reflected (R4 R6 R7)
        run_frame(20, 20, 0, 1, 0, 0, 100, 0);
        // factor 5 wide spread: 2,7,12,17,22 style (R5)
        run_frame(25, 5, 'h8000, 5, 0, 1, 100, 0);
        // up-scaling, fraction-only step, carries into center (R3)
        run_frame(10, 23, 'h8000, 0, 'h6F00, 0, 50, 0);
        // zero output height (R9)
        run_frame(16, 0, 0, 1, 0, 0, 100, 0);
        // single-line image: all taps clamp to 0 (R6 R7)
        run_frame(1, 4, 0, 0, 'h4000, 1, 70, 0);
        // wide with zero integer step falls back to spacing 1 (R5)
        run_frame(8, 6, 'h1234, 0, 'hC000, 1, 80, 0);
        // mid-frame start pulses and config changes (R10 R11)
        run_frame(30, 12, 'h2000, 2, 'h3000, 1, 40, 1);
        run_frame(30, 12, 'h2000, 2, 'h3000, 0, 40, 0);

        for (int t = 0; t < 30; t++) begin
            int inh, outh, si, sfr, sf, wd, pct;
            inh  = 1 + int'($urandom % 40);
            outh = 1 + int'($urandom % 30);
            si   = int'($urandom % 5);
            sfr  = int'($urandom % 65536);
            sf   = int'($urandom % 65536);
            wd   = int'($urandom % 2);
            pct  = 30 + int'($urandom % 71);
            run_frame(inh, outh, sf, si, sfr, wd, pct, (t % 7) == 3);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule